// File: doc/BRIEF.md
# GO/DONE Four-Phase Request-Acknowledge Pair

This block joins a requesting state machine and a working state machine through two level signals, a request (`go`) and an acknowledge (`done`). A start request on the requesting side raises `go`. The working side notices the rising request and spends a fixed, parameter-set number of busy cycles on it. It then raises `done` and holds it until the request drops. The requester keeps `go` high until it has seen `done`, then drops it. It accepts a new start only after it has also seen `done` fall, so each transaction runs all four phases: request up, acknowledge up, request down, acknowledge down.

Each side runs on its own clock and its own active-low reset. Each reset is asserted asynchronously and released through a two-flop reset synchronizer. A parameter sets the depth of the synchronizer chain that each crossing signal passes through in its receiving domain. A depth of two or more lets the two clocks be unrelated. A depth of zero wires the crossings straight through, for a shared clock or for a slave clock that is an exact, edge-aligned multiple of the master clock. What the working side computes during its busy cycles is left out.

Top module: `gd_handshake_pair`

## Requirements
- R1: While a reset is asserted, and after release until a start request is accepted, `go` and `done` are both low.
- R2: When the master is idle and samples `start_req` high on a `clk_m` edge, `go` is high after that edge. The master samples `start_req` only when idle.
- R3: Once high, `go` stays high until the master's synchronized copy of `done` is high. With a shared clock and chain depth L, `go` falls 1+L `clk_m` cycles after `done` rises.
- R4: With a shared clock, `done` rises BUSY_CYCLES+1+L cycles after `go` rises. The slave spends exactly BUSY_CYCLES cycles in its busy state.
- R5: Once high, `done` stays high until the slave's synchronized copy of `go` is low. With a shared clock, `done` falls 1+L cycles after `go` falls.
- R6: Once it has dropped `go`, the master ignores `start_req` until it has seen `done` low. With `start_req` held high on a shared clock, the next rise of `go` comes exactly 3+2L cycles after the fall of `go`.
- R7: SYNC_STAGES=0 adds no latency to either crossing. SYNC_STAGES=N adds N receiving-clock cycles to each crossing.
- R8: On any pair of clocks, `go` never falls while `done` is low, and `done` never falls while `go` is high.
- R9: With `start_req` held high on unrelated clocks or on an edge-aligned half-rate slave clock, the pair keeps completing handshakes. BUSY_CYCLES=1, the minimum, is supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master clock |
| rst_m_n | input | 1 | Master-domain reset, active low, asynchronous assert |
| clk_s | input | 1 | Slave clock |
| rst_s_n | input | 1 | Slave-domain reset, active low, asynchronous assert |
| start_req | input | 1 | Start request, in the master domain |
| go | output | 1 | Request level driven by the master |
| done | output | 1 | Acknowledge level driven by the slave |

## Verification
The bench builds four copies. Two share one clock and run against a lockstep model: BUSY_CYCLES=3 with no synchronizers, and BUSY_CYCLES=1 with two-stage chains. Between them these reach exact edge timing for both latency settings and the minimum busy length. A third copy runs BUSY_CYCLES=4 with two-stage chains on a 7.3 ns slave clock against the 5 ns master clock. A fourth runs BUSY_CYCLES=2 with direct wiring on an edge-aligned half-rate slave clock. These last two bring the protocol ordering and handshake progress under unrelated and ratioed clocks within reach.

// File: rtl/gd_pkg.sv
package gd_pkg;

  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_REQ   = 2'd1,
    M_DRAIN = 2'd2
  } mst_state_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WORK = 2'd1,
    S_ACK  = 2'd2
  } slv_state_t;

endpackage

// File: rtl/gd_rst_sync.sv
module gd_rst_sync #(
  parameter int unsigned STAGES = gd_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/gd_sync.sv
module gd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i+1] <= 1'b0;
      else        chain[i+1] <= chain[i];
    end
  end

  assign q_o = chain[STAGES];

endmodule

// File: rtl/gd_master.sv
module gd_master
  import gd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req_i,
  input  logic done_seen_i,
  output logic go_o
);

  mst_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      M_IDLE:  if (start_req_i)  state_d = M_REQ;
      M_REQ:   if (done_seen_i)  state_d = M_DRAIN;
      M_DRAIN: if (!done_seen_i) state_d = M_IDLE;
      default:                   state_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= M_IDLE;
    else        state_q <= state_d;
  end

  assign go_o = (state_q == M_REQ);

  // R2: a request only starts from an accepted start
  a_r2_go_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_o) |-> $past(start_req_i) && !$past(done_seen_i));

  // R3: request holds until acknowledge is seen
  a_r3_go_holds: assert property (@(posedge clk) disable iff (!rst_n)
    go_o && !done_seen_i |=> go_o);

  // R3: request drops only after acknowledge seen
  a_r3_go_fall_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_o) |-> $past(done_seen_i));

  // R6: no immediate re-request after the drop
  a_r6_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_o) |=> !go_o);

endmodule

// File: rtl/gd_slave.sv
module gd_slave
  import gd_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_seen_i,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  slv_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      S_IDLE: if (go_seen_i) begin
        state_d = S_WORK;
        cnt_d   = CNT_W'(BUSY_CYCLES - 1);
        cnt_en  = 1'b1;
      end
      S_WORK: begin
        if (cnt_q == '0) state_d = S_ACK;
        else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      S_ACK:  if (!go_seen_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (state_q == S_ACK);

  // checker-side count of cycles spent busy
  logic [CNT_W-1:0] work_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 work_seen_q <= '0;
    else if (state_q == S_WORK) work_seen_q <= work_seen_q + 1'b1;
    else                        work_seen_q <= '0;
  end

  // R4: acknowledge follows exactly BUSY_CYCLES busy cycles
  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> work_seen_q == CNT_W'(BUSY_CYCLES));

  // R5: acknowledge holds while request still seen
  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && go_seen_i |=> done_o);

  // R5: acknowledge drops only after request seen low
  a_r5_done_fall_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_o) |-> !$past(go_seen_i));

endmodule

// File: rtl/gd_handshake_pair.sv
module gd_handshake_pair #(
  parameter int unsigned BUSY_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_m,
  input  logic rst_m_n,
  input  logic clk_s,
  input  logic rst_s_n,
  input  logic start_req,
  output logic go,
  output logic done
);

  logic m_rst_n, s_rst_n;
  logic done_seen, go_seen;

  gd_rst_sync u_rst_m (.clk(clk_m), .arst_n(rst_m_n), .srst_n(m_rst_n));
  gd_rst_sync u_rst_s (.clk(clk_s), .arst_n(rst_s_n), .srst_n(s_rst_n));

  gd_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(clk_m), .rst_n(m_rst_n), .d_i(done), .q_o(done_seen)
  );

  gd_sync #(.STAGES(SYNC_STAGES)) u_sync_go (
    .clk(clk_s), .rst_n(s_rst_n), .d_i(go), .q_o(go_seen)
  );

  gd_master u_master (
    .clk(clk_m), .rst_n(m_rst_n), .start_req_i(start_req),
    .done_seen_i(done_seen), .go_o(go)
  );

  gd_slave #(.BUSY_CYCLES(BUSY_CYCLES)) u_slave (
    .clk(clk_s), .rst_n(s_rst_n), .go_seen_i(go_seen), .done_o(done)
  );

endmodule

// File: tb/gd_handshake_pair_tb_top.sv
module gd_lockstep_chk #(
  parameter int B = 3,
  parameter int L = 0
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic go,
  input logic done
);
  int n_chk = 0;
  int n_bad = 0;

  int m_ph, s_ph, s_rem;
  bit m_go, s_done, go_v, dn_v, armed;
  bit gq[$];
  bit dq[$];

  int cyc = 0;
  int t_go_rise, t_go_fall, t_done_rise, t_done_fall;
  bit have_go_rise, have_done_rise, have_go_fall, start_dropped;
  bit p_go, p_done;

  initial begin
    m_ph = 0; s_ph = 0; s_rem = 0; m_go = 0; s_done = 0; armed = 0;
    have_go_rise = 0; have_done_rise = 0; have_go_fall = 0; start_dropped = 1;
    p_go = 0; p_done = 0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s B=%0d L=%0d cyc=%0d actual=%0d expected=%0d", tag, B, L, cyc, act, exp);
    end
  endtask

  // behavioural model, updated on each clock edge
  always @(posedge clk) begin
    cyc++;
    armed = 1;
    if (!start) start_dropped = 1;
    if (!rst_n) begin
      m_ph = 0; s_ph = 0; m_go = 0; s_done = 0;
      gq.delete(); dq.delete();
    end else begin
      gq.push_back(m_go);
      dq.push_back(s_done);
      go_v = (gq.size() > L) ? gq[gq.size()-1-L] : 1'b0;
      dn_v = (dq.size() > L) ? dq[dq.size()-1-L] : 1'b0;
      case (m_ph)
        0: if (start) m_ph = 1;
        1: if (dn_v) m_ph = 2;
        default: if (!dn_v) m_ph = 0;
      endcase
      case (s_ph)
        0: if (go_v) begin s_ph = 1; s_rem = B; end
        1: begin s_rem--; if (s_rem == 0) s_ph = 2; end
        default: if (!go_v) s_ph = 0;
      endcase
      m_go = (m_ph == 1);
      s_done = (s_ph == 2);
      if (gq.size() > 16) void'(gq.pop_front());
      if (dq.size() > 16) void'(dq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(go === m_go, "R2/R3/R6 go lockstep", int'(go), int'(m_go));
      chk(done === s_done, "R4/R5/R9 done lockstep", int'(done), int'(s_done));
      if (go && !p_go) begin
        if (have_go_fall && !start_dropped)
          chk(cyc - t_go_fall == 3 + 2*L, "R6 re-request gap", cyc - t_go_fall, 3 + 2*L);
        t_go_rise = cyc; have_go_rise = 1;
      end
      if (done && !p_done && have_go_rise) begin
        chk(cyc - t_go_rise == B + 1 + L, "R4/R7 go-to-done", cyc - t_go_rise, B + 1 + L);
        t_done_rise = cyc; have_done_rise = 1;
      end
      if (!go && p_go && have_done_rise) begin
        chk(cyc - t_done_rise == 1 + L, "R3/R7 done-to-go-fall", cyc - t_done_rise, 1 + L);
        t_go_fall = cyc; have_go_fall = 1; start_dropped = 0;
      end
      if (!done && p_done && have_go_fall) begin
        t_done_fall = cyc;
        chk(t_done_fall - t_go_fall == 1 + L, "R5/R7 go-fall-to-done-fall", t_done_fall - t_go_fall, 1 + L);
      end
      p_go = go; p_done = done;
    end
  end
endmodule

module gd_proto_mon (
  input logic rst_n,
  input logic go,
  input logic done
);
  int n_chk = 0;
  int n_bad = 0;
  int n_hs = 0;

  always @(negedge go) if (rst_n === 1'b1) begin
    n_chk++;
    if (done !== 1'b1) begin
      n_bad++;
      $display("FAIL R8 go fell with done low: actual done=%0d expected=1", done);
    end
  end

  always @(negedge done) if (rst_n === 1'b1) begin
    n_chk++;
    n_hs++;
    if (go !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 done fell with go high: actual go=%0d expected=0", go);
    end
  end
endmodule

module gd_handshake_pair_tb_top;
  logic clk, clk_h, clk_x, rst_n;
  logic start_a, start_b;
  logic go_i, done_i, go_s, done_s, go_x, done_x, go_h, done_h;
  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;
  bit finished = 0;

  initial begin clk = 0; forever #2.5 clk = ~clk; end
  initial begin clk_h = 0; #2.5; forever begin clk_h = 1; #5; clk_h = 0; #5; end end
  initial begin clk_x = 0; forever #3.65 clk_x = ~clk_x; end

  gd_handshake_pair #(.BUSY_CYCLES(3), .SYNC_STAGES(0)) dut_i (
    .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk), .rst_s_n(rst_n),
    .start_req(start_a), .go(go_i), .done(done_i));
  gd_handshake_pair #(.BUSY_CYCLES(1), .SYNC_STAGES(2)) dut_s (
    .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk), .rst_s_n(rst_n),
    .start_req(start_a), .go(go_s), .done(done_s));
  gd_handshake_pair #(.BUSY_CYCLES(4), .SYNC_STAGES(2)) dut_x (
    .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk_x), .rst_s_n(rst_n),
    .start_req(start_b), .go(go_x), .done(done_x));
  gd_handshake_pair #(.BUSY_CYCLES(2), .SYNC_STAGES(0)) dut_h (
    .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk_h), .rst_s_n(rst_n),
    .start_req(start_b), .go(go_h), .done(done_h));

  gd_lockstep_chk #(.B(3), .L(0)) lk_i (.clk(clk), .rst_n(rst_n), .start(start_a), .go(go_i), .done(done_i));
  gd_lockstep_chk #(.B(1), .L(2)) lk_s (.clk(clk), .rst_n(rst_n), .start(start_a), .go(go_s), .done(done_s));
  gd_proto_mon pm_x (.rst_n(rst_n), .go(go_x), .done(done_x));
  gd_proto_mon pm_h (.rst_n(rst_n), .go(go_h), .done(done_h));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      n_chk += lk_i.n_chk + lk_s.n_chk + pm_x.n_chk + pm_h.n_chk;
      n_bad += lk_i.n_bad + lk_s.n_bad + pm_x.n_bad + pm_h.n_bad;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", wd);
      finish_run();
    end
  end

  initial begin
    int lfsr;
    rst_n = 0; start_a = 0; start_b = 0;
    repeat (4) @(negedge clk);
    // R1: during reset
    chk({go_i, done_i, go_s, done_s, go_x, done_x, go_h, done_h} == 8'h00,
        "R1 outputs in reset", {go_i, done_i, go_s, done_s, go_x, done_x, go_h, done_h}, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    // R1: after release, no start yet
    chk({go_i, done_i, go_s, done_s, go_x, done_x, go_h, done_h} == 8'h00,
        "R1 outputs idle after release", {go_i, done_i, go_s, done_s, go_x, done_x, go_h, done_h}, 0);

    // R2: single start pulse
    start_a = 1;
    @(negedge clk);
    start_a = 0;
    chk(go_i == 1'b1, "R2 go after accepted start", go_i, 1);
    chk(go_s == 1'b1, "R2 go after accepted start, synced pair", go_s, 1);
    repeat (30) @(negedge clk);
    chk(go_i == 0 && done_i == 0, "R5 both low after one handshake", {go_i, done_i}, 0);

    // R6: start pulse while busy is ignored for a new transaction
    start_a = 1; @(negedge clk); start_a = 0;
    repeat (3) @(negedge clk);
    start_a = 1; @(negedge clk); start_a = 0;
    repeat (30) @(negedge clk);
    chk(go_i == 0 && done_i == 0, "R6 mid-busy start not queued", {go_i, done_i}, 0);

    // R6: held start, back-to-back transactions
    start_a = 1;
    start_b = 1;
    repeat (80) @(negedge clk);
    start_a = 0;
    repeat (20) @(negedge clk);

    // mixed pattern
    lfsr = 32'h1d;
    for (int k = 0; k < 300; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      start_a = lfsr[0] & lfsr[3];
      @(negedge clk);
    end
    start_a = 0;
    repeat (300) @(negedge clk);

    // R8/R9: independent and ratioed clocks made progress
    chk(pm_x.n_hs >= 5, "R9 handshakes on unrelated clocks", pm_x.n_hs, 5);
    chk(pm_h.n_hs >= 5, "R9 handshakes on half-rate clock", pm_h.n_hs, 5);
    chk(pm_x.n_chk > 0 && pm_h.n_chk > 0, "R8 ordering checks ran", pm_x.n_chk, 1);
    finish_run();
  end
endmodule